// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns raw colour-table words, as fetched from memory by a separate loader, into one uniform internal entry: 8-bit red, green and blue channels plus a single transparency flag. A load begins with a one-cycle `start` pulse. At that edge the block captures the configured raw layout (one of four), the monochrome flag and the pixel-depth code. It then accepts raw words over a valid/ready handshake. Each accepted word produces one write into a palette RAM port. Writes go to consecutive addresses starting from 0, and `done` pulses once the last one has been issued.

The pixel-depth code sets the number of entries. A direct-colour depth needs no table: the block issues no write and only raises `done`. The block also keeps the layout it last captured. It flags `reparseReq` whenever the configured layout no longer matches that stored value, which tells the surrounding logic that the table has to be rebuilt.

Top module: `palette_entry_converter`

## Requirements
- R1: After reset `rawReady`, `palWe` and `done` are low and `reparseReq` is high.
- R2: Depth code 1 loads 4 entries, code 2 loads 16 and code 3 loads 256. The writes go to addresses 0, 1, 2 and upward, with one write in the cycle after each accepted beat.
- R3: Any other depth code issues no write and keeps `rawReady` low. `done` is high in the second cycle after the `start` edge.
- R4: Layout 0 takes a 16-bit word from `rawData[15:0]`: red from bits 15:11, green from bits 10:5, blue from bits 4:0. The transparency flag is always 0.
- R5: Layout 1 takes red from bits 23:19, green from bits 15:10, blue from bits 7:3, and transparency from bit 24.
- R6: Layout 2 takes red from bits 23:18, green from bits 15:10, blue from bits 7:2, and transparency from bit 24.
- R7: Layout 3 takes red from bits 23:16, green from bits 15:8, blue from bits 7:0, and transparency from bit 24.
- R8: With monochrome set, `rawData[7:0]` goes to all three channels. The layout's transparency rule still applies.
- R9: `done` is high for exactly one cycle, in the cycle after the final write.
- R10: A `start` pulse, or a change of configuration, while a load is in progress has no effect on that load's entry count, addresses or conversion.
- R11: `reparseReq` is high when `cfgFormat` differs from the layout captured at the last `start` accepted while idle, or when no `start` has yet been accepted. Otherwise it is low.
- R12: A cycle in which `rawValid` is low during a load produces no write and does not advance the address.
- Output word `palData` holds transparency in bit 24, red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Channel bits not filled by the raw field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load; captures the configuration when idle |
| cfgFormat | input | 2 | Raw palette layout select (0 to 3) |
| cfgMono | input | 1 | Monochrome override |
| cfgDepth | input | 4 | Pixel-depth code |
| rawValid | input | 1 | Raw word valid |
| rawData | input | 32 | Raw palette word |
| rawReady | output | 1 | Block accepts raw words |
| palWe | output | 1 | Palette RAM write enable |
| palAddr | output | ADDR_W | Palette RAM write address |
| palData | output | 25 | Converted entry {T, R, G, B} |
| done | output | 1 | One-cycle end-of-load pulse |
| reparseReq | output | 1 | Configured layout differs from the stored one |

## Verification
The hardest case to reach from the ports is a `start` pulse with a new layout arriving during a load, on the same edge as an accepted beat. If that pulse were honoured it would silently restart the address count or switch the conversion part way through the table. The stimulus raises `start` and flips `cfgFormat` together with the third beat of a 16-entry load. The scoreboard still expects 16 entries in the original layout, and `reparseReq` is checked afterwards. Stall cycles are also inserted between beats, and the full 256-entry load is run to cover the address wrap at the top of the table.

// File: rtl/palconv_pkg.sv
package palconv_pkg;

  localparam int CH_W  = 8;
  localparam int RAW_W = 32;
  localparam int PAL_W = 3 * CH_W + 1;

  localparam logic [3:0] DEPTH_2BPP = 4'd1;
  localparam logic [3:0] DEPTH_4BPP = 4'd2;
  localparam logic [3:0] DEPTH_8BPP = 4'd3;

  localparam logic [1:0] FMT_16B      = 2'd0;
  localparam logic [1:0] FMT_32B_555  = 2'd1;
  localparam logic [1:0] FMT_32B_666  = 2'd2;
  localparam logic [1:0] FMT_32B_888  = 2'd3;

  localparam int TRANSP_BIT = 24;

  typedef struct packed {
    logic            transp;
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } palEntry_t;

  typedef struct packed {
    logic capture;
    logic accept;
    logic finish;
  } ctrlStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } ctrlState_t;

  function automatic palEntry_t convertEntry(input logic [RAW_W-1:0] raw,
                                             input logic [1:0] fmt,
                                             input logic mono);
    palEntry_t e;
    e = '0;
    case (fmt)
      FMT_16B: begin
        e.red    = {raw[15:11], 3'b000};
        e.green  = {raw[10:5], 2'b00};
        e.blue   = {raw[4:0], 3'b000};
        e.transp = 1'b0;
      end
      FMT_32B_555: begin
        e.red    = {raw[23:19], 3'b000};
        e.green  = {raw[15:10], 2'b00};
        e.blue   = {raw[7:3], 3'b000};
        e.transp = raw[TRANSP_BIT];
      end
      FMT_32B_666: begin
        e.red    = {raw[23:18], 2'b00};
        e.green  = {raw[15:10], 2'b00};
        e.blue   = {raw[7:2], 2'b00};
        e.transp = raw[TRANSP_BIT];
      end
      default: begin
        e.red    = raw[23:16];
        e.green  = raw[15:8];
        e.blue   = raw[7:0];
        e.transp = raw[TRANSP_BIT];
      end
    endcase
    if (mono) begin
      e.red   = raw[CH_W-1:0];
      e.green = raw[CH_W-1:0];
      e.blue  = raw[CH_W-1:0];
    end
    return e;
  endfunction

endpackage

// File: rtl/palconv_ctrl.sv
module palconv_ctrl
  import palconv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        cfgDepth,
  input  logic              rawValid,
  output logic              rawReady,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] entryIdx,
  output logic              done
);

  ctrlState_t        stateQ;
  logic [ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0] lastIdxQ;
  logic [ADDR_W-1:0] lastIdxD;
  logic              hasPal;
  logic              isLast;
  logic              doneArmQ;
  logic              doneQ;

  // Entry count from depth: 2^(bits per pixel), stored as last index.
  always_comb begin
    hasPal   = 1'b1;
    lastIdxD = '0;
    case (cfgDepth)
      DEPTH_2BPP: lastIdxD = ADDR_W'(3);
      DEPTH_4BPP: lastIdxD = ADDR_W'(15);
      DEPTH_8BPP: lastIdxD = ADDR_W'(255);
      default:    hasPal   = 1'b0;
    endcase
  end

  always_comb begin
    strobe.capture = (stateQ == ST_IDLE) && start;
    strobe.accept  = (stateQ == ST_LOAD) && rawValid;
    isLast         = strobe.accept && (idxQ == lastIdxQ);
    strobe.finish  = (strobe.capture && !hasPal) || isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      idxQ     <= '0;
      lastIdxQ <= '0;
      doneArmQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      if (strobe.capture) begin
        idxQ     <= '0;
        lastIdxQ <= lastIdxD;
        stateQ   <= hasPal ? ST_LOAD : ST_IDLE;
      end else if (strobe.accept) begin
        idxQ <= idxQ + 1'b1;
        if (isLast) stateQ <= ST_IDLE;
      end
      doneArmQ <= strobe.finish;
      doneQ    <= doneArmQ;
    end
  end

  assign rawReady = (stateQ == ST_LOAD);
  assign entryIdx = idxQ;
  assign done     = doneQ;

endmodule

// File: rtl/palconv_datapath.sv
module palconv_datapath
  import palconv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] entryIdx,
  input  logic [1:0]        cfgFormat,
  input  logic              cfgMono,
  input  logic [RAW_W-1:0]  rawData,
  output logic              palWe,
  output logic [ADDR_W-1:0] palAddr,
  output logic [PAL_W-1:0]  palData,
  output logic              reparseReq
);

  logic [1:0]        fmtQ;
  logic              monoQ;
  logic [1:0]        lastFmtQ;
  logic              lastValidQ;
  logic              palWeQ;
  logic [ADDR_W-1:0] palAddrQ;
  palEntry_t         palDataQ;
  palEntry_t         convD;

  always_comb convD = convertEntry(rawData, fmtQ, monoQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ       <= FMT_16B;
      monoQ      <= 1'b0;
      lastFmtQ   <= FMT_16B;
      lastValidQ <= 1'b0;
    end else if (strobe.capture) begin
      fmtQ       <= cfgFormat;
      monoQ      <= cfgMono;
      lastFmtQ   <= cfgFormat;
      lastValidQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      palWeQ   <= 1'b0;
      palAddrQ <= '0;
      palDataQ <= '0;
    end else begin
      palWeQ <= strobe.accept;
      if (strobe.accept) begin
        palAddrQ <= entryIdx;
        palDataQ <= convD;
      end
    end
  end

  assign palWe      = palWeQ;
  assign palAddr    = palAddrQ;
  assign palData    = palDataQ;
  assign reparseReq = !lastValidQ || (cfgFormat != lastFmtQ);

endmodule

// File: rtl/palette_entry_converter.sv
module palette_entry_converter
  import palconv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cfgFormat,
  input  logic              cfgMono,
  input  logic [3:0]        cfgDepth,
  input  logic              rawValid,
  input  logic [31:0]       rawData,
  output logic              rawReady,
  output logic              palWe,
  output logic [ADDR_W-1:0] palAddr,
  output logic [24:0]       palData,
  output logic              done,
  output logic              reparseReq
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] entryIdx;

  palconv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgDepth (cfgDepth),
    .rawValid (rawValid),
    .rawReady (rawReady),
    .strobe   (strobe),
    .entryIdx (entryIdx),
    .done     (done)
  );

  palconv_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .entryIdx   (entryIdx),
    .cfgFormat  (cfgFormat),
    .cfgMono    (cfgMono),
    .rawData    (rawData),
    .palWe      (palWe),
    .palAddr    (palAddr),
    .palData    (palData),
    .reparseReq (reparseReq)
  );

endmodule

// File: rtl/palconv_checker.sv
module palconv_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        cfgFormat,
  input logic              cfgMono,
  input logic [3:0]        cfgDepth,
  input logic              rawValid,
  input logic [31:0]       rawData,
  input logic              rawReady,
  input logic              palWe,
  input logic [ADDR_W-1:0] palAddr,
  input logic [24:0]       palData,
  input logic              done,
  input logic              reparseReq
);

  logic [1:0] fmtTrk;
  logic       monoTrk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtTrk  <= 2'd0;
      monoTrk <= 1'b0;
    end else if (start && !rawReady) begin
      fmtTrk  <= cfgFormat;
      monoTrk <= cfgMono;
    end
  end

  AST_WRITE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    palWe |-> $past(rawValid && rawReady)); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (palWe && $past(palWe)) |-> (palAddr == $past(palAddr) + 1'b1)); // R2

  AST_FMT0_OPAQUE: assert property (@(posedge clk) disable iff (!rstN)
    (palWe && fmtTrk == 2'd0) |-> !palData[24]); // R4

  AST_MONO_GREY: assert property (@(posedge clk) disable iff (!rstN)
    (palWe && monoTrk) |-> (palData[23:16] == palData[15:8] &&
                            palData[15:8] == palData[7:0])); // R8

  AST_FORMAT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !rawReady) |=> (!reparseReq || cfgFormat != $past(cfgFormat))); // R11

endmodule

bind palette_entry_converter palconv_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_palette_entry_converter.sv
`timescale 1ns/1ps
module tb_palette_entry_converter;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        cfgFormat = 2'd0;
  logic              cfgMono = 1'b0;
  logic [3:0]        cfgDepth = 4'd0;
  logic              rawValid = 1'b0;
  logic [31:0]       rawData = 32'd0;
  logic              rawReady;
  logic              palWe;
  logic [ADDR_W-1:0] palAddr;
  logic [24:0]       palData;
  logic              done;
  logic              reparseReq;

  palette_entry_converter #(.ADDR_W(ADDR_W)) dut (.*);

  always #2 clk = ~clk;

  typedef struct { logic [ADDR_W-1:0] addr; logic [24:0] data; } exp_t;
  exp_t expQ[$];
  int checks = 0;
  int fails  = 0;
  string curReq = "R2";

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Reference conversion written from the requirement text.
  function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f,
                                        input logic m);
    logic [7:0] r, g, b;
    logic t;
    t = (f == 2'd0) ? 1'b0 : w[24];
    if (f == 2'd0) begin
      r = 8'((w >> 11) & 32'h1f) << 3;
      g = 8'((w >> 5) & 32'h3f) << 2;
      b = 8'(w & 32'h1f) << 3;
    end else if (f == 2'd1) begin
      r = 8'((w >> 19) & 32'h1f) << 3;
      g = 8'((w >> 10) & 32'h3f) << 2;
      b = 8'((w >> 3) & 32'h1f) << 3;
    end else if (f == 2'd2) begin
      r = 8'((w >> 18) & 32'h3f) << 2;
      g = 8'((w >> 10) & 32'h3f) << 2;
      b = 8'((w >> 2) & 32'h3f) << 2;
    end else begin
      r = 8'(w >> 16);
      g = 8'(w >> 8);
      b = 8'(w);
    end
    if (m) begin
      r = w[7:0]; g = w[7:0]; b = w[7:0];
    end
    return {t, r, g, b};
  endfunction

  // Monitor: compares every write against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && palWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12 unexpected write", 32'(palAddr), 32'hffffffff);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(palAddr == e.addr, "R2 address", 32'(palAddr), 32'(e.addr));
        check(palData == e.data, curReq, 32'(palData), 32'(e.data));
      end
    end
  end

  task automatic runLoad(input logic [3:0] depth, input logic [1:0] fmt,
                         input logic mono, input bit stall, input bit midStart,
                         input string req);
    int n;
    n = (depth == 4'd1) ? 4 : (depth == 4'd2) ? 16 : (depth == 4'd3) ? 256 : 0;
    curReq = req;
    @(negedge clk);
    cfgDepth = depth; cfgFormat = fmt; cfgMono = mono; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (n == 0) begin
      @(negedge clk);
      check(!done && !rawReady, "R3 first cycle", {30'd0, done, rawReady}, 32'd0);
      @(negedge clk);
      check(done, "R3 done", 32'(done), 32'd1);
      check(!rawReady, "R3 ready", 32'(rawReady), 32'd0);
      @(negedge clk);
      check(!done, "R9 single", 32'(done), 32'd0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 1)) begin
        rawValid = 1'b0;
        @(posedge clk); #1;
      end
      rawData  = $urandom;
      rawValid = 1'b1;
      expQ.push_back('{addr: ADDR_W'(i), data: model(rawData, fmt, mono)});
      if (midStart && i == 2) begin
        start = 1'b1;
        cfgFormat = fmt ^ 2'd1;
        cfgDepth = 4'd1;
      end
      @(posedge clk); #1;
      rawValid = 1'b0;
      start = 1'b0;
    end
    @(negedge clk);
    check(!done, "R9 early", 32'(done), 32'd0);
    @(negedge clk);
    check(done, "R9 done", 32'(done), 32'd1);
    check(expQ.size() == 0, "R2 count", 32'(expQ.size()), 32'd0);
    check(!rawReady, "R10 ended", 32'(rawReady), 32'd0);
    @(negedge clk);
    check(!done, "R9 single", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!rawReady && !palWe && !done, "R1 outputs",
          {29'd0, rawReady, palWe, done}, 32'd0);
    check(reparseReq, "R1 reparse", 32'(reparseReq), 32'd1);

    runLoad(4'd1, 2'd0, 1'b0, 1'b0, 1'b0, "R4");
    check(!reparseReq, "R11 same", 32'(reparseReq), 32'd0);
    cfgFormat = 2'd2; #1;
    check(reparseReq, "R11 changed", 32'(reparseReq), 32'd1);

    runLoad(4'd2, 2'd1, 1'b0, 1'b1, 1'b0, "R5 R12");
    runLoad(4'd3, 2'd2, 1'b0, 1'b0, 1'b0, "R6");
    runLoad(4'd2, 2'd3, 1'b0, 1'b1, 1'b0, "R7");
    runLoad(4'd1, 2'd3, 1'b1, 1'b0, 1'b0, "R8");
    runLoad(4'd2, 2'd0, 1'b1, 1'b0, 1'b0, "R8");
    runLoad(4'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R3");
    runLoad(4'd4, 2'd1, 1'b0, 1'b0, 1'b0, "R3");
    runLoad(4'd15, 2'd1, 1'b0, 1'b0, 1'b0, "R3");
    check(!reparseReq, "R11 direct depth", 32'(reparseReq), 32'd0);
    runLoad(4'd2, 2'd1, 1'b0, 1'b0, 1'b1, "R10");
    check(reparseReq, "R10 R11 ignored start", 32'(reparseReq), 32'd1);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule